// File: doc/BRIEF.md
# Frame Span Node Walker

This block steers a periodic schedule walk each time a frame span traversal node turns up. For each node it receives the node's forward (normal-path) link and its terminate bit, the backward link and its terminate bit, and the current micro-frame number. One cycle later it reports the next link to fetch and whether that link ends the periodic list. It also keeps a recovery-mode flag and one saved link.

In micro-frames 0 and 1 the walker can leave the current frame's schedule. A node that marks a save place stores the forward link and sends the walk along the backward link, so that the previous frame's low/full-speed interrupt queue heads get their service. The next node that marks a restore returns the walk to the stored link. In every later micro-frame each node simply passes the walk along its forward link. A pulse at the start of each frame clears the stored state.

Top module: `fstn_walker`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows next_valid=0, end_of_list=0 and recovery=0.
- R2: A presented node (node_valid=1, node_is_fstn=1) in micro-frame 2 to 7 gives next_ptr = normal_ptr and end_of_list = normal_t, and leaves recovery unchanged.
- R3: A presented node with back_t=0 (save place) in micro-frame 0 or 1 gives next_ptr = back_ptr and end_of_list=0. It stores normal_ptr and normal_t and sets recovery to 1.
- R4: A presented node with back_t=1 (restore) in micro-frame 0 or 1 while recovery is 1 gives next_ptr = the stored pointer and end_of_list = the stored terminate bit, and clears recovery.
- R5: A restore node in micro-frame 0 or 1 while recovery is 0 gives next_ptr = normal_ptr and end_of_list = normal_t.
- R6: frame_start=1 clears recovery and the stored pointer, so a later restore node follows its normal path.
- R7: A cycle with node_valid=0 or node_is_fstn=0 gives next_valid=0 on the following cycle and leaves recovery and the stored pointer unchanged.
- R8: Every presented node gives exactly one next_valid=1 cycle, on the cycle after it is presented, and next_ptr and end_of_list hold the result of that node.
- R9: When frame_start and a node arrive in the same cycle, the node is judged with recovery already cleared. A save node in that cycle still sets recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Pulse at the start of each frame |
| node_valid | input | 1 | A node is presented this cycle |
| node_is_fstn | input | 1 | Presented node is a frame span traversal node |
| uframe | input | UF_W (3) | Current micro-frame number |
| normal_ptr | input | PTR_W (27) | Forward link of the node |
| normal_t | input | 1 | Terminate bit of the forward link |
| back_ptr | input | PTR_W (27) | Backward link of the node |
| back_t | input | 1 | 0 = save place, 1 = restore |
| next_valid | output | 1 | Result strobe, one cycle after the node |
| next_ptr | output | PTR_W (27) | Next link to fetch |
| end_of_list | output | 1 | Next link ends the periodic list |
| recovery | output | 1 | Recovery-path mode is active |

## Verification
The bench targets the edge between micro-frames 1 and 2. A design that tests the micro-frame range wrongly would take the backward detour in micro-frame 2, or skip it in micro-frame 1. It also runs a restore outside recovery mode, where a faulty walker would jump to a stale stored link. It covers a save node whose own forward link is terminated, which the restore must then report as end of list. The bench sends a frame-start pulse in the same cycle as a restore node and a save node to show that frame-start priority is handled, then ignored node types, then long random runs checked against a bench model.

// File: rtl/fstn_pkg.sv
// Shared types for the frame span node walker.
// Assumes: one node is judged per cycle; the action code is internal only.
package fstn_pkg;
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,  // no node or not a span node
        ACT_NORMAL  = 2'd1,  // follow the forward link
        ACT_SAVE    = 2'd2,  // store forward link, take backward link
        ACT_RESTORE = 2'd3   // return to the stored link
    } fstn_act_e;
endpackage

// File: rtl/fstn_decode.sv
// Classifies a presented node into one walk action.
// Assumes: rec_eff is the recovery flag with any same-cycle frame clear applied.
module fstn_decode
    import fstn_pkg::*;
#(
    parameter int UF_W        = 3,
    parameter int REC_UF_LAST = 1
) (
    input  logic            node_valid,
    input  logic            node_is_fstn,
    input  logic [UF_W-1:0] uframe,
    input  logic            back_t,
    input  logic            rec_eff,
    output fstn_act_e       act
);
    localparam logic [UF_W-1:0] LAST_UF = REC_UF_LAST[UF_W-1:0];

    logic in_window;

    // Purpose: flag the micro-frames where the detour may be taken.
    always_comb in_window = (uframe <= LAST_UF);

    // Purpose: pick the action from the window, the node kind and the mode.
    always_comb begin
        act = ACT_NONE;
        if (node_valid && node_is_fstn) begin
            if (!in_window)
                act = ACT_NORMAL;
            else if (!back_t)
                act = ACT_SAVE;
            else if (rec_eff)
                act = ACT_RESTORE;
            else
                act = ACT_NORMAL;
        end
    end
endmodule

// File: rtl/fstn_state.sv
// Holds the recovery flag and the stored forward link.
// Assumes: a save in the same cycle as frame_start wins over the clear.
module fstn_state
    import fstn_pkg::*;
#(
    parameter int PTR_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  fstn_act_e        act,
    input  logic [PTR_W-1:0] normal_ptr,
    input  logic             normal_t,
    output logic             recovery,
    output logic [PTR_W-1:0] saved_ptr,
    output logic             saved_t
);
    // Purpose: update mode and stored link on save, restore and frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recovery  <= 1'b0;
            saved_ptr <= '0;
            saved_t   <= 1'b0;
        end else if (act == ACT_SAVE) begin
            recovery  <= 1'b1;
            saved_ptr <= normal_ptr;
            saved_t   <= normal_t;
        end else if (frame_start || act == ACT_RESTORE) begin
            recovery  <= 1'b0;
            saved_ptr <= '0;
            saved_t   <= 1'b0;
        end
    end

    p_save_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_SAVE |=> recovery);
    p_restore_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_RESTORE |=> !recovery);
    p_frame_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && act != ACT_SAVE) |=> !recovery);
    p_normal_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_NORMAL && !frame_start) |=> $stable(recovery));
    p_idle_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_NONE && !frame_start) |=> ($stable(recovery) && $stable(saved_ptr)));
endmodule

// File: rtl/fstn_next.sv
// Registers the next link, its terminate flag and the result strobe.
// Assumes: saved_ptr/saved_t are the values before this cycle's update.
module fstn_next
    import fstn_pkg::*;
#(
    parameter int PTR_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fstn_act_e        act,
    input  logic [PTR_W-1:0] normal_ptr,
    input  logic             normal_t,
    input  logic [PTR_W-1:0] back_ptr,
    input  logic [PTR_W-1:0] saved_ptr,
    input  logic             saved_t,
    output logic             next_valid,
    output logic [PTR_W-1:0] next_ptr,
    output logic             end_of_list
);
    logic [PTR_W-1:0] sel_ptr;
    logic             sel_t;

    // Purpose: choose the link that the action points to.
    always_comb begin
        unique case (act)
            ACT_SAVE:    begin sel_ptr = back_ptr;   sel_t = 1'b0;     end
            ACT_RESTORE: begin sel_ptr = saved_ptr;  sel_t = saved_t;  end
            default:     begin sel_ptr = normal_ptr; sel_t = normal_t; end
        endcase
    end

    // Purpose: capture the result one cycle after the node.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_valid  <= 1'b0;
            next_ptr    <= '0;
            end_of_list <= 1'b0;
        end else begin
            next_valid <= (act != ACT_NONE);
            if (act != ACT_NONE) begin
                next_ptr    <= sel_ptr;
                end_of_list <= sel_t;
            end
        end
    end

    p_save_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_SAVE |=> (next_ptr == $past(back_ptr) && !end_of_list));
    p_normal_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_NORMAL |=> (next_ptr == $past(normal_ptr) && end_of_list == $past(normal_t)));
endmodule

// File: rtl/fstn_walker.sv
// Top of the frame span node walker: decode, mode state and next-link register.
// Assumes: at most one node per cycle; the result appears one cycle later.
module fstn_walker
    import fstn_pkg::*;
#(
    parameter int PTR_W       = 27,
    parameter int UF_W        = 3,
    parameter int REC_UF_LAST = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             node_valid,
    input  logic             node_is_fstn,
    input  logic [UF_W-1:0]  uframe,
    input  logic [PTR_W-1:0] normal_ptr,
    input  logic             normal_t,
    input  logic [PTR_W-1:0] back_ptr,
    input  logic             back_t,
    output logic             next_valid,
    output logic [PTR_W-1:0] next_ptr,
    output logic             end_of_list,
    output logic             recovery
);
    fstn_act_e        act;
    logic             rec_eff;
    logic [PTR_W-1:0] saved_ptr;
    logic             saved_t;

    // Purpose: a frame start in this cycle hides the old recovery mode.
    always_comb rec_eff = recovery && !frame_start;

    fstn_decode #(.UF_W(UF_W), .REC_UF_LAST(REC_UF_LAST)) u_decode (
        .node_valid   (node_valid),
        .node_is_fstn (node_is_fstn),
        .uframe       (uframe),
        .back_t       (back_t),
        .rec_eff      (rec_eff),
        .act          (act)
    );

    fstn_state #(.PTR_W(PTR_W)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .act         (act),
        .normal_ptr  (normal_ptr),
        .normal_t    (normal_t),
        .recovery    (recovery),
        .saved_ptr   (saved_ptr),
        .saved_t     (saved_t)
    );

    fstn_next #(.PTR_W(PTR_W)) u_next (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .normal_ptr  (normal_ptr),
        .normal_t    (normal_t),
        .back_ptr    (back_ptr),
        .saved_ptr   (saved_ptr),
        .saved_t     (saved_t),
        .next_valid  (next_valid),
        .next_ptr    (next_ptr),
        .end_of_list (end_of_list)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!next_valid && !recovery && !end_of_list));
    p_one_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (node_valid && node_is_fstn) |=> next_valid);
    p_no_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(node_valid && node_is_fstn) |=> !next_valid);
    p_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && node_valid && node_is_fstn && back_t) |=> !recovery);
endmodule

// File: tb/tb_fstn_walker.sv
`timescale 1ns/1ps
module tb_fstn_walker;
    localparam int PTR_W = 27;
    localparam int UF_W  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic             node_valid = 1'b0;
    logic             node_is_fstn = 1'b0;
    logic [UF_W-1:0]  uframe = '0;
    logic [PTR_W-1:0] normal_ptr = '0;
    logic             normal_t = 1'b0;
    logic [PTR_W-1:0] back_ptr = '0;
    logic             back_t = 1'b0;
    logic             next_valid;
    logic [PTR_W-1:0] next_ptr;
    logic             end_of_list;
    logic             recovery;

    int total = 0;
    int bad = 0;

    // model state
    logic             m_rec = 1'b0;
    logic [PTR_W-1:0] m_sptr = '0;
    logic             m_st = 1'b0;

    always #2 clk = ~clk;

    fstn_walker dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .node_valid(node_valid), .node_is_fstn(node_is_fstn), .uframe(uframe),
        .normal_ptr(normal_ptr), .normal_t(normal_t), .back_ptr(back_ptr),
        .back_t(back_t), .next_valid(next_valid), .next_ptr(next_ptr),
        .end_of_list(end_of_list), .recovery(recovery)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle, step the model, check the registered result after the edge.
    task automatic cycle(input string req, input logic fs, input logic v, input logic f,
                         input logic [UF_W-1:0] uf, input logic [PTR_W-1:0] np, input logic nt,
                         input logic [PTR_W-1:0] bp, input logic bt);
        logic             e_v;
        logic [PTR_W-1:0] e_p;
        logic             e_t;
        logic             rec_eff;
        frame_start = fs; node_valid = v; node_is_fstn = f; uframe = uf;
        normal_ptr = np; normal_t = nt; back_ptr = bp; back_t = bt;
        rec_eff = m_rec && !fs;
        e_v = v && f;
        e_p = np; e_t = nt;
        if (e_v && uf <= 1) begin
            if (!bt) begin
                e_p = bp; e_t = 1'b0;
                m_rec = 1'b1; m_sptr = np; m_st = nt;
            end else if (rec_eff) begin
                e_p = m_sptr; e_t = m_st;
                m_rec = 1'b0; m_sptr = '0; m_st = 1'b0;
            end else if (fs) begin
                m_rec = 1'b0; m_sptr = '0; m_st = 1'b0;
            end
        end else if (fs) begin
            m_rec = 1'b0; m_sptr = '0; m_st = 1'b0;
        end
        @(posedge clk); #1;
        check({req, " valid"}, 32'(next_valid), 32'(e_v));
        if (e_v) begin
            check({req, " ptr"}, 32'(next_ptr), 32'(e_p));
            check({req, " eol"}, 32'(end_of_list), 32'(e_t));
        end
        check({req, " recovery"}, 32'(recovery), 32'(m_rec));
    endtask

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", 32'(next_valid), 0);
        check("R1 recovery", 32'(recovery), 0);
        check("R1 eol", 32'(end_of_list), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: micro-frames 2..7 follow forward link, including terminate
        cycle("R2", 0, 1, 1, 3'd2, 27'h0123, 1'b0, 27'h0777, 1'b0);
        cycle("R2", 0, 1, 1, 3'd7, 27'h0456, 1'b1, 27'h0777, 1'b1);
        // R5: restore out of recovery follows forward link
        cycle("R5", 0, 1, 1, 3'd1, 27'h0abc, 1'b0, 27'h0555, 1'b1);
        // R3: save in micro-frame 1 with terminated forward link
        cycle("R3", 0, 1, 1, 3'd1, 27'h1111, 1'b1, 27'h2222, 1'b0);
        // R7: ignored node types and idle keep state
        cycle("R7", 0, 1, 0, 3'd0, 27'h3333, 1'b0, 27'h4444, 1'b1);
        cycle("R7", 0, 0, 1, 3'd0, 27'h3333, 1'b0, 27'h4444, 1'b1);
        // R2: micro-frame 2 restore-kind node does not return
        cycle("R2", 0, 1, 1, 3'd2, 27'h5555, 1'b0, 27'h6666, 1'b1);
        // R4: restore returns stored link with its terminate bit
        cycle("R4", 0, 1, 1, 3'd0, 27'h7777, 1'b0, 27'h0001, 1'b1);
        // R3 then R6: frame start clears, restore then follows forward link
        cycle("R3", 0, 1, 1, 3'd0, 27'h0aaa, 1'b0, 27'h0bbb, 1'b0);
        cycle("R6", 1, 0, 0, 3'd0, 27'h0, 1'b0, 27'h0, 1'b0);
        cycle("R6", 0, 1, 1, 3'd0, 27'h0ccc, 1'b0, 27'h0ddd, 1'b1);
        // R9: frame start with restore in the same cycle
        cycle("R3", 0, 1, 1, 3'd1, 27'h0eee, 1'b0, 27'h0fff, 1'b0);
        cycle("R9", 1, 1, 1, 3'd1, 27'h1234, 1'b1, 27'h4321, 1'b1);
        // R9: frame start with save in the same cycle keeps the save
        cycle("R9", 1, 1, 1, 3'd0, 27'h2468, 1'b0, 27'h1357, 1'b0);
        cycle("R4", 0, 1, 1, 3'd1, 27'h0, 1'b1, 27'h0, 1'b1);
        // R8: back-to-back nodes each give one result
        cycle("R8", 0, 1, 1, 3'd4, 27'h0101, 1'b0, 27'h0, 1'b0);
        cycle("R8", 0, 1, 1, 3'd5, 27'h0202, 1'b0, 27'h0, 1'b0);
        cycle("R8", 0, 0, 0, 3'd5, 27'h0202, 1'b0, 27'h0, 1'b0);

        // random mix biased toward micro-frames 0 and 1
        for (int i = 0; i < 3000; i++) begin
            logic [UF_W-1:0] uf;
            uf = ($urandom % 3 == 0) ? UF_W'($urandom % 8) : UF_W'($urandom % 2);
            cycle("R8 random", ($urandom % 16) == 0, ($urandom % 5) != 0,
                  ($urandom % 6) != 0, uf, PTR_W'($urandom), ($urandom % 4) == 0,
                  PTR_W'($urandom), $urandom % 2 == 1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule